// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the byte-level engine of an I2C master. Software writes a command word that can request any mix of four phases: open a transfer with an address, send one byte, receive one byte, and close the transfer. The engine then runs the requested phases one after another. For each phase it makes a single request/response exchange with a byte-level bus agent. That agent handles the bit timing on the wire.

A data buffer register supplies the address byte for the opening phase and the byte for the send phase. The engine also keeps a small state field that shows what the master is doing. It uses this field, not the bus line level, to decide whether a close request is legal. A close request that arrives while no transfer is open is reported as abnormal and never reaches the bus. Four interrupt status bits report the outcome of the last command.

Top module: `i2c_cmd_seq`

## Requirements
- R1: A command write taken while `busy` is low loads the request bits, clears `irqStatus` to zero and sets `busy` from the next cycle on. A command write while `busy` is high is ignored. Request bits are: bit0 open, bit1 send, bit2 receive, bit3 receive-last, bit4 close.
- R2: The requested phases run in a fixed order: open, send, receive, close. Each phase is one exchange on the bus port with the op codes open=0, send=1, receive=2, close=3. `busReqValid` and `busReqOp` stay steady until `busReqReady` is seen.
- R3: During the open phase the state field reads 2 (repeated open) if the master was active and 1 otherwise. The phase presents buffer bits 7:1 as the address and buffer bit 0 as the direction.
- R4: If the open phase is not acknowledged, the TX-NAK status bit (bit1) is set and the send and receive phases of that command are skipped. The state field is then 0 (idle). An acknowledged open phase leaves the state field at 3 (active).
- R5: During the send phase the state field reads 4 and the buffer byte is presented. An acknowledge sets TX-ACK (bit0). A missing acknowledge sets only TX-NAK (bit1). Either way the state field returns to 3.
- R6: A receive phase runs when either receive bit is set. During it the state field reads 5. `busReqNack` is high exactly when receive-last is set. Afterwards the state field returns to 3 and `rxData` holds the received byte.
- R7: If the bus agent reports a read error, `rxData` becomes 0xFF.
- R8: A close request while the state field is 3, 4 or 5 runs a close exchange with the state field at 6 and sets normal-stop (bit2). A close request in any other state sets abnormal-stop (bit3) and makes no bus exchange. In both cases the state field ends at 0.
- R9: Each phase clears its own request bit when it completes. `busy` falls once no request bit remains. `cmdRegRd` shows the request bits in bits 4:0 and the state field in bits 8:5.
- R10: A buffer write while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmdWrEn | input | 1 | Command write strobe |
| cmdWrData | input | 5 | Request bits of the command write |
| bufWrEn | input | 1 | Buffer write strobe |
| bufWrData | input | DATA_W | Buffer write value |
| cmdRegRd | output | 9 | Command register readout: state field and pending requests |
| rxData | output | DATA_W | Last received byte |
| irqStatus | output | 4 | TX-ACK, TX-NAK, normal-stop, abnormal-stop |
| busy | output | 1 | High while requested phases remain |
| busReqValid | output | 1 | Phase request to the bus agent |
| busReqOp | output | 2 | Phase op code |
| busReqAddr | output | DATA_W-1 | Target address for the open phase |
| busReqRead | output | 1 | Direction bit for the open phase |
| busReqData | output | DATA_W | Byte for the send phase |
| busReqNack | output | 1 | Answer the received byte with NACK |
| busReqReady | input | 1 | Bus agent completes the current phase |
| busRspNak | input | 1 | Open or send was not acknowledged |
| busRspData | input | DATA_W | Received byte |
| busRspErr | input | 1 | Read failed |

## Verification
The bench builds the block with the default 8-bit data width, so the address, direction and 0xFF error value are checked in their natural layout. Random request mixes with random bus delays reach every phase combination. They include a close that follows a refused open, a repeated open taken from the active state, and a close issued from idle. Directed cases add writes during a busy command and a failed read.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_START  = 4'd1,
    ST_RSTART = 4'd2,
    ST_ACTIVE = 4'd3,
    ST_TXD    = 4'd4,
    ST_RXD    = 4'd5,
    ST_STOP   = 4'd6
  } mstState_t;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_END   = 2'd3
  } busOp_t;

  localparam int REQ_START  = 0;
  localparam int REQ_TX     = 1;
  localparam int REQ_RX     = 2;
  localparam int REQ_RXLAST = 3;
  localparam int REQ_STOP   = 4;
  localparam int REQ_W      = 5;

  localparam int IRQ_TXACK = 0;
  localparam int IRQ_TXNAK = 1;
  localparam int IRQ_NSTOP = 2;
  localparam int IRQ_ABORT = 3;
  localparam int IRQ_W     = 4;

  localparam int STATE_W = 4;

  typedef struct packed {
    logic      loadCmd;
    logic      setState;
    mstState_t nextState;
    logic      clrStart;
    logic      clrTx;
    logic      clrRx;
    logic      clrStop;
    logic      irqTxAck;
    logic      irqTxNak;
    logic      irqNormStop;
    logic      irqAbnormal;
    logic      loadRx;
  } strobes_t;

  function automatic logic isActive(mstState_t s);
    return (s == ST_ACTIVE) || (s == ST_TXD) || (s == ST_RXD);
  endfunction

endpackage

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdWrEn,
  input  logic [REQ_W-1:0] reqBits,
  input  mstState_t        mstState,
  input  logic             busReqReady,
  input  logic             busRspNak,
  output strobes_t         strb,
  output logic             busy,
  output logic             busReqValid,
  output busOp_t           busReqOp
);

  typedef enum logic [1:0] {C_IDLE, C_ENTER, C_WAIT} ctrlPhase_t;

  ctrlPhase_t curPh, nxtPh;
  busOp_t     curOp, selOp;

  logic pendStart, pendTx, pendRx, pendStop;
  assign pendStart = reqBits[REQ_START];
  assign pendTx    = reqBits[REQ_TX];
  assign pendRx    = reqBits[REQ_RX] | reqBits[REQ_RXLAST];
  assign pendStop  = reqBits[REQ_STOP];

  always_comb begin
    strb  = '0;
    strb.nextState = ST_IDLE;
    nxtPh = curPh;
    selOp = OP_START;
    unique case (curPh)
      C_IDLE: begin
        if (cmdWrEn) begin
          strb.loadCmd = 1'b1;
          nxtPh = C_ENTER;
        end
      end
      C_ENTER: begin
        if (pendStart) begin
          strb.setState  = 1'b1;
          strb.nextState = isActive(mstState) ? ST_RSTART : ST_START;
          selOp = OP_START;
          nxtPh = C_WAIT;
        end else if (pendTx) begin
          strb.setState  = 1'b1;
          strb.nextState = ST_TXD;
          selOp = OP_SEND;
          nxtPh = C_WAIT;
        end else if (pendRx) begin
          strb.setState  = 1'b1;
          strb.nextState = ST_RXD;
          selOp = OP_RECV;
          nxtPh = C_WAIT;
        end else if (pendStop) begin
          if (isActive(mstState)) begin
            strb.setState  = 1'b1;
            strb.nextState = ST_STOP;
            selOp = OP_END;
            nxtPh = C_WAIT;
          end else begin
            strb.irqAbnormal = 1'b1;
            strb.clrStop     = 1'b1;
            strb.setState    = 1'b1;
            strb.nextState   = ST_IDLE;
          end
        end else begin
          nxtPh = C_IDLE;
        end
      end
      C_WAIT: begin
        if (busReqReady) begin
          nxtPh = C_ENTER;
          strb.setState  = 1'b1;
          strb.nextState = ST_ACTIVE;
          unique case (curOp)
            OP_START: begin
              strb.clrStart = 1'b1;
              if (busRspNak) begin
                strb.irqTxNak  = 1'b1;
                strb.clrTx     = 1'b1;
                strb.clrRx     = 1'b1;
                strb.nextState = ST_IDLE;
              end
            end
            OP_SEND: begin
              strb.clrTx    = 1'b1;
              strb.irqTxNak = busRspNak;
              strb.irqTxAck = ~busRspNak;
            end
            OP_RECV: begin
              strb.clrRx  = 1'b1;
              strb.loadRx = 1'b1;
            end
            OP_END: begin
              strb.clrStop     = 1'b1;
              strb.irqNormStop = 1'b1;
              strb.nextState   = ST_IDLE;
            end
            default: ;
          endcase
        end
      end
      default: nxtPh = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curPh <= C_IDLE;
      curOp <= OP_START;
    end else begin
      curPh <= nxtPh;
      if (curPh == C_ENTER) curOp <= selOp;
    end
  end

  assign busy        = (curPh != C_IDLE);
  assign busReqValid = (curPh == C_WAIT);
  assign busReqOp    = curOp;

  assert_hold_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid && !busReqReady |=> busReqValid && $stable(busReqOp));

  assert_send_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid && busReqOp == OP_SEND |-> mstState == ST_TXD);

  assert_recv_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid && busReqOp == OP_RECV |-> mstState == ST_RXD);

  assert_stop_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busReqValid && busReqOp == OP_END |-> mstState == ST_STOP);

  assert_idle_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> reqBits == '0);

endmodule

// File: rtl/i2c_cmd_dp.sv
module i2c_cmd_dp
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strb,
  input  logic              busy,
  input  logic [REQ_W-1:0]  cmdWrData,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              busRspErr,
  input  logic [DATA_W-1:0] busRspData,
  output logic [REQ_W-1:0]  reqBits,
  output mstState_t         mstState,
  output logic [DATA_W-1:0] rxData,
  output logic [IRQ_W-1:0]  irqStatus,
  output logic [DATA_W-2:0] busReqAddr,
  output logic              busReqRead,
  output logic [DATA_W-1:0] busReqData,
  output logic              busReqNack
);

  logic [DATA_W-1:0] bufReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqBits   <= '0;
      mstState  <= ST_IDLE;
      rxData    <= '0;
      irqStatus <= '0;
      bufReg    <= '0;
    end else begin
      if (bufWrEn && !busy) bufReg <= bufWrData;
      if (strb.loadCmd) begin
        reqBits   <= cmdWrData;
        irqStatus <= '0;
      end else begin
        if (strb.clrStart) reqBits[REQ_START] <= 1'b0;
        if (strb.clrTx)    reqBits[REQ_TX]    <= 1'b0;
        if (strb.clrRx) begin
          reqBits[REQ_RX]     <= 1'b0;
          reqBits[REQ_RXLAST] <= 1'b0;
        end
        if (strb.clrStop)     reqBits[REQ_STOP]  <= 1'b0;
        if (strb.irqTxAck)    irqStatus[IRQ_TXACK] <= 1'b1;
        if (strb.irqTxNak)    irqStatus[IRQ_TXNAK] <= 1'b1;
        if (strb.irqNormStop) irqStatus[IRQ_NSTOP] <= 1'b1;
        if (strb.irqAbnormal) irqStatus[IRQ_ABORT] <= 1'b1;
      end
      if (strb.setState) mstState <= strb.nextState;
      if (strb.loadRx) rxData <= busRspErr ? {DATA_W{1'b1}} : busRspData;
    end
  end

  assign busReqAddr  = bufReg[DATA_W-1:1];
  assign busReqRead  = bufReg[0];
  assign busReqData  = bufReg;
  assign busReqNack  = reqBits[REQ_RXLAST];

  assert_ack_nak_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irqStatus[IRQ_TXACK] && irqStatus[IRQ_TXNAK]));

  assert_stop_kind_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(irqStatus[IRQ_NSTOP] && irqStatus[IRQ_ABORT]));

  assert_load_clears_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb.loadCmd |=> irqStatus == '0);

  assert_buf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(busReqData));

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_cmd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmdWrEn,
  input  logic [REQ_W-1:0]         cmdWrData,
  input  logic                     bufWrEn,
  input  logic [DATA_W-1:0]        bufWrData,
  output logic [STATE_W+REQ_W-1:0] cmdRegRd,
  output logic [DATA_W-1:0]        rxData,
  output logic [IRQ_W-1:0]         irqStatus,
  output logic                     busy,
  output logic                     busReqValid,
  output logic [1:0]               busReqOp,
  output logic [DATA_W-2:0]        busReqAddr,
  output logic                     busReqRead,
  output logic [DATA_W-1:0]        busReqData,
  output logic                     busReqNack,
  input  logic                     busReqReady,
  input  logic                     busRspNak,
  input  logic [DATA_W-1:0]        busRspData,
  input  logic                     busRspErr
);

  strobes_t         strb;
  logic [REQ_W-1:0] reqBits;
  mstState_t        mstState;
  busOp_t           opSel;

  i2c_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmdWrEn(cmdWrEn), .reqBits(reqBits),
    .mstState(mstState), .busReqReady(busReqReady), .busRspNak(busRspNak),
    .strb(strb), .busy(busy), .busReqValid(busReqValid), .busReqOp(opSel)
  );

  i2c_cmd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .busy(busy), .cmdWrData(cmdWrData),
    .bufWrEn(bufWrEn), .bufWrData(bufWrData), .busRspErr(busRspErr),
    .busRspData(busRspData), .reqBits(reqBits), .mstState(mstState),
    .rxData(rxData), .irqStatus(irqStatus), .busReqAddr(busReqAddr),
    .busReqRead(busReqRead), .busReqData(busReqData), .busReqNack(busReqNack)
  );

  assign busReqOp = opSel;
  assign cmdRegRd = {mstState, reqBits};

endmodule

// File: tb/i2c_cmd_seq_test.sv
module i2c_cmd_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmdWrEn = 1'b0;
  logic [4:0] cmdWrData = '0;
  logic bufWrEn = 1'b0;
  logic [7:0] bufWrData = '0;
  logic [8:0] cmdRegRd;
  logic [7:0] rxData;
  logic [3:0] irqStatus;
  logic busy, busReqValid, busReqRead, busReqNack;
  logic [1:0] busReqOp;
  logic [6:0] busReqAddr;
  logic [7:0] busReqData;
  logic busReqReady = 1'b0;
  logic busRspNak = 1'b0;
  logic [7:0] busRspData = '0;
  logic busRspErr = 1'b0;

  i2c_cmd_seq uut (.*);

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  int cycles = 0;

  // bus agent knobs
  logic nakOpen, nakSend, rdErr;
  logic [7:0] rdByte;
  int waitCnt = 0;
  int logN = 0;
  int logOp[8], logSt[8], logAddr[8], logRd[8], logData[8], logNack[8];

  // bench reference state
  int modelSt = 0;
  int modelRx = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finishRun();
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      busReqReady = 1'b0;
    end else if (busReqReady) begin
      busReqReady = 1'b0;
    end else if (busReqValid) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        if (logN < 8) begin
          logOp[logN] = int'(busReqOp); logSt[logN] = int'(cmdRegRd[8:5]);
          logAddr[logN] = int'(busReqAddr); logRd[logN] = int'(busReqRead);
          logData[logN] = int'(busReqData); logNack[logN] = int'(busReqNack);
        end
        logN++;
        busRspNak  = (busReqOp == 2'd0) ? nakOpen : nakSend;
        busRspErr  = rdErr;
        busRspData = rdByte;
        busReqReady = 1'b1;
        waitCnt = $urandom % 3;
      end
    end
  end

  function automatic bit actv(int s);
    return s == 3 || s == 4 || s == 5;
  endfunction

  task automatic runCmd(input logic [4:0] bits, input logic [7:0] bufv,
                        input bit nO, input bit nS, input bit rE,
                        input logic [7:0] rB, input bit poke);
    int expOp[4], expSt[4];
    int n = 0;
    int expIrq = 0;
    bit skip = 0;
    nakOpen = nO; nakSend = nS; rdErr = rE; rdByte = rB;
    // reference model
    if (bits[0]) begin
      expOp[n] = 0; expSt[n] = actv(modelSt) ? 2 : 1; n++;
      if (nO) begin expIrq |= 2; modelSt = 0; skip = 1; end
      else modelSt = 3;
    end
    if (bits[1] && !skip) begin
      expOp[n] = 1; expSt[n] = 4; n++;
      expIrq |= nS ? 2 : 1; modelSt = 3;
    end
    if ((bits[2] || bits[3]) && !skip) begin
      expOp[n] = 2; expSt[n] = 5; n++;
      modelRx = rE ? 255 : int'(rB); modelSt = 3;
    end
    if (bits[4]) begin
      if (actv(modelSt)) begin expOp[n] = 3; expSt[n] = 6; n++; expIrq |= 4; end
      else expIrq |= 8;
      modelSt = 0;
    end
    // drive
    @(negedge clk); bufWrEn = 1; bufWrData = bufv;
    @(negedge clk); bufWrEn = 0; cmdWrEn = 1; cmdWrData = bits; logN = 0;
    @(negedge clk); cmdWrEn = 0;
    check(busy === 1'b1, "R1 busy after write", int'(busy), 1);
    check(irqStatus === 4'd0, "R1 status cleared", int'(irqStatus), 0);
    if (poke) begin
      cmdWrEn = 1; cmdWrData = 5'h10; bufWrEn = 1; bufWrData = ~bufv;
      @(negedge clk); cmdWrEn = 0; bufWrEn = 0;
    end
    while (busy) @(negedge clk);
    check(logN == n, "R2 phase count", logN, n);
    for (int i = 0; i < n && i < logN; i++) begin
      check(logOp[i] == expOp[i], "R2 phase order", logOp[i], expOp[i]);
      if (expOp[i] == 0) begin
        check(logSt[i] == expSt[i], "R3 open state", logSt[i], expSt[i]);
        check(logAddr[i] == int'(bufv[7:1]), "R3 address", logAddr[i], int'(bufv[7:1]));
        check(logRd[i] == int'(bufv[0]), "R3 direction", logRd[i], int'(bufv[0]));
      end else if (expOp[i] == 1) begin
        check(logSt[i] == 4, "R5 send state", logSt[i], 4);
        check(logData[i] == int'(bufv), "R5 R10 send byte", logData[i], int'(bufv));
      end else if (expOp[i] == 2) begin
        check(logSt[i] == 5, "R6 recv state", logSt[i], 5);
        check(logNack[i] == int'(bits[3]), "R6 nack flag", logNack[i], int'(bits[3]));
      end else begin
        check(logSt[i] == 6, "R8 stop state", logSt[i], 6);
      end
    end
    check(int'(irqStatus) == expIrq, "R4 R5 R8 status", int'(irqStatus), expIrq);
    check(int'(cmdRegRd[8:5]) == modelSt, "R4 R8 final state", int'(cmdRegRd[8:5]), modelSt);
    check(cmdRegRd[4:0] == 5'd0, "R9 requests cleared", int'(cmdRegRd[4:0]), 0);
    check(int'(rxData) == modelRx, "R6 R7 rxData", int'(rxData), modelRx);
  endtask

  initial begin
    void'($urandom(32'd2024));
    nakOpen = 0; nakSend = 0; rdErr = 0; rdByte = 0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && irqStatus === 4'd0 && cmdRegRd === 9'd0 && busReqValid === 1'b0,
          "R9 reset state", int'(cmdRegRd), 0);
    rst_n = 1;
    @(negedge clk);
    // close from idle: abnormal, no exchange (R8)
    runCmd(5'h10, 8'h00, 0, 0, 0, 8'h00, 0);
    // open+send+close, all acknowledged (R2 R3 R5 R8)
    runCmd(5'h13, 8'hA4, 0, 0, 0, 8'h00, 0);
    // open+send, then repeated open + receive-last (R3 R6)
    runCmd(5'h03, 8'h5A, 0, 0, 0, 8'h00, 0);
    runCmd(5'h09, 8'h5B, 0, 0, 0, 8'h3C, 0);
    // send refused: only TX-NAK, then normal close (R5)
    runCmd(5'h12, 8'h77, 0, 1, 0, 8'h00, 0);
    // refused open skips send and receive, close is abnormal (R4)
    runCmd(5'h17, 8'hC2, 1, 0, 0, 8'h11, 0);
    // failed read gives 0xFF (R7)
    runCmd(5'h15, 8'h31, 0, 0, 1, 8'h22, 0);
    // writes while busy ignored (R1 R10)
    runCmd(5'h03, 8'h6E, 0, 0, 0, 8'h00, 1);
    runCmd(5'h10, 8'h00, 0, 0, 0, 8'h00, 0);
    // empty command
    runCmd(5'h00, 8'h00, 0, 0, 0, 8'h00, 0);
    // random mix
    for (int k = 0; k < 60; k++) begin
      runCmd(5'($urandom), 8'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0,
             ($urandom % 5) == 0, 8'($urandom), ($urandom % 6) == 0);
    end
    finishRun();
  end

endmodule